// File: doc/BRIEF.md
# Complementary Dead-Time Gate Sequencer

This block turns a single pulse-width-modulated command into two gate-drive commands for a complementary switch pair: a main switch output and an auxiliary switch output. The two switches must never conduct together. Each of the two turn-on edges is held back by its own programmable gap, given as a count of clock cycles. A turn-off always happens at once. A per-output mode bit lets a zero-voltage sense input end a gap early. The programmed count still sets the longest wait.

The command input and both sense inputs pass through two-flop synchronizers before the sequencer acts on them. An active-high enable puts the block to sleep. In sleep the main output is held low and the auxiliary output is released, with its output-enable low. A build parameter sets the auxiliary polarity. One choice drives an n-channel switch with a true complement, the other drives a p-channel switch with an inverted level. With a 100 MHz clock and gaps well under half a period, the block follows switching rates up to 1 MHz.

In this brief, "aux conducting" means the auxiliary switch is commanded on. The latency of the command path is counted from the first rising clock edge at which a changed `pwm_in` is sampled. That edge is cycle 1. The two synchronizer stages take cycles 1 and 2, and the sequencer register acts at cycle 3.

Top module: `cgate_seq`

## Requirements
- R1: When `pwm_in` rises while the aux switch conducts, the aux switch stops conducting at cycle 3.
- R2: In timed mode, `pwr_out` rises exactly max(`dly_main`,1) cycles after the aux switch stops conducting, and never earlier.
- R3: When `pwm_in` falls while `pwr_out` is high, `pwr_out` goes low at cycle 3. A turn-off always wins over a pending turn-on.
- R4: In timed mode, the aux switch starts conducting again exactly max(`dly_aux`,1) cycles after `pwr_out` falls, and never earlier.
- R5: Zero-voltage sense behaves as follows:
  - With `zv_mode_main`=1, a high on `zv_main` during the main wait turns `pwr_out` on 3 cycles after `zv_main` is first sampled high. The same holds for `zv_aux`, `zv_mode_aux` and the aux wait.
  - The programmed gap remains the upper bound.
  - With the mode bit at 0, the sense input has no effect.
- R6: If `pwm_in` returns to its old level before a pending gap ends, that turn-on is dropped and its timer restarts from zero.
  - A dropped main turn-on returns the aux switch to conduction one cycle after the synchronized change.
  - A dropped aux turn-on leaves the aux switch off and starts a full main gap.
- R7: `pwr_out` high and the aux switch conducting never occur in the same cycle.
- R8: One cycle after `en` is low, the block is asleep: `pwr_out`=0, `aux_oe`=0, and `aux_out` sits at its off level. It stays so whatever `pwm_in` does.
- R9: When `en` returns to 1, the sequencer leaves sleep one cycle later with `aux_oe`=1 and `pwr_out` low.
  - If the synchronized input is high, `pwr_out` rises max(`dly_main`,1) cycles after that.
  - If it is low, the aux switch starts conducting max(`dly_aux`,1) cycles after that.
- R10: While synchronous reset `rst` is high, `pwr_out`=0, `aux_oe`=0 and `aux_out` is at its off level. Both timers and the synchronizers are cleared.
- R11: The aux output level depends on `AUX_INV`:
  - With `AUX_INV`=0, `aux_out`=1 means conducting.
  - With `AUX_INV`=1, `aux_out`=0 means conducting.
  - In every cycle the two builds give opposite `aux_out` levels and the same `pwr_out` and `aux_oe`.
- R12: A gap count of 0 behaves exactly like a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; low puts the block to sleep |
| pwm_in | input | 1 | Asynchronous switching command |
| zv_main | input | 1 | Zero-voltage sense for the main switch (asynchronous) |
| zv_aux | input | 1 | Zero-voltage sense for the aux switch (asynchronous) |
| zv_mode_main | input | 1 | 1: main gap may end on `zv_main` |
| zv_mode_aux | input | 1 | 1: aux gap may end on `zv_aux` |
| dly_main | input | CNT_W | Main turn-on gap in cycles (0 acts as 1) |
| dly_aux | input | CNT_W | Aux turn-on gap in cycles (0 acts as 1) |
| pwr_out | output | 1 | Main gate command, high = on |
| aux_out | output | 1 | Aux gate command, level set by `AUX_INV` |
| aux_oe | output | 1 | Aux output-enable; low = high impedance |

## Verification
The assertions are checked on every cycle:
- non-overlap of the two conduction commands, and that the main turn-on only follows a cycle with the aux switch off;
- the one-cycle turn-off reaction to the synchronized input;
- that no turn-on happens while its timer is running and no sense release applies;
- the sleep response to `en`.

Only the bench scenarios can show the exact gap lengths. The bench sweeps both gap counts, including zero, and checks the three-cycle synchronizer latency, the early release on a sense input, and the restart after a cancelled edge. It also checks the wake-up order out of sleep and the opposite polarity of a second build.

// File: rtl/cgate_seq_pkg.sv
package cgate_seq_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP     = 3'd0,
    ST_AUX_ON    = 3'd1,
    ST_WAIT_MAIN = 3'd2,
    ST_MAIN_ON   = 3'd3,
    ST_WAIT_AUX  = 3'd4
  } seq_state_e;

  // A programmed gap of zero is treated as one cycle.
  function automatic int unsigned eff_cycles(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // The timer starts at zero on the cycle its wait begins. It ends once the
  // count, plus the evaluating cycle, reaches the effective gap.
  function automatic logic gap_elapsed(input int unsigned elapsed,
                                       input int unsigned d);
    return (elapsed + 1) >= eff_cycles(d);
  endfunction

endpackage

// File: rtl/cgate_sync.sv
module cgate_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cgate_timer.sv
module cgate_timer
  import cgate_seq_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  localparam int ACC_W = CNT_W + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst || !run)            elapsed <= '0;
    else if (elapsed != ACC_MAX) elapsed <= elapsed + 1'b1;
  end

  assign done = run && gap_elapsed(32'(elapsed), 32'(limit));

  // R12: a zero limit must release on the first evaluated cycle of a wait
  p_zero_gap_r12: assert property (@(posedge clk) disable iff (rst)
    (run && elapsed == '0 && limit == '0) |-> done);

endmodule

// File: rtl/cgate_fsm.sv
module cgate_fsm
  import cgate_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cmd_s,
  input  logic zv_main_s,
  input  logic zv_aux_s,
  input  logic mode_main,
  input  logic mode_aux,
  input  logic done_main,
  input  logic done_aux,
  output logic run_main,
  output logic run_aux,
  output logic pwr_q,
  output logic auxc_q,
  output logic oe_q
);

  seq_state_e state, nxt;

  // Named events, brought out for the properties below
  logic rise_seen, fall_seen, main_release, aux_release;
  logic main_cancel, aux_cancel;

  assign rise_seen    = en && cmd_s &&
                        (state == ST_AUX_ON || state == ST_WAIT_AUX || state == ST_SLEEP);
  assign fall_seen    = en && !cmd_s &&
                        (state == ST_MAIN_ON || state == ST_WAIT_MAIN || state == ST_SLEEP);
  assign main_release = en && cmd_s && state == ST_WAIT_MAIN &&
                        (done_main || (mode_main && zv_main_s));
  assign aux_release  = en && !cmd_s && state == ST_WAIT_AUX &&
                        (done_aux || (mode_aux && zv_aux_s));
  assign main_cancel  = en && !cmd_s && state == ST_WAIT_MAIN;
  assign aux_cancel   = en && cmd_s && state == ST_WAIT_AUX;

  always_comb begin
    nxt = state;
    if (!en) begin
      nxt = ST_SLEEP;
    end else begin
      unique case (state)
        ST_SLEEP:     nxt = cmd_s ? ST_WAIT_MAIN : ST_WAIT_AUX;
        ST_AUX_ON:    if (cmd_s) nxt = ST_WAIT_MAIN;
        ST_WAIT_MAIN: begin
          if (!cmd_s)            nxt = ST_AUX_ON;
          else if (main_release) nxt = ST_MAIN_ON;
        end
        ST_MAIN_ON:   if (!cmd_s) nxt = ST_WAIT_AUX;
        ST_WAIT_AUX:  begin
          if (cmd_s)            nxt = ST_WAIT_MAIN;
          else if (aux_release) nxt = ST_AUX_ON;
        end
        default:      nxt = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_SLEEP;
      pwr_q  <= 1'b0;
      auxc_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      state  <= nxt;
      pwr_q  <= (nxt == ST_MAIN_ON);
      auxc_q <= (nxt == ST_AUX_ON);
      oe_q   <= (nxt != ST_SLEEP);
    end
  end

  assign run_main = (state == ST_WAIT_MAIN);
  assign run_aux  = (state == ST_WAIT_AUX);

  // R7: the two conduction commands never meet
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    !(pwr_q && auxc_q));

  // R7: main turn-on only after a cycle with the aux switch off
  p_gap_before_main_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_q) |-> $past(!auxc_q));

  // R1: a synchronized rise drops aux conduction in one cycle
  p_aux_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (en && cmd_s && auxc_q) |=> !auxc_q);

  // R3: a synchronized fall drops the main command in one cycle
  p_main_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !cmd_s && pwr_q) |=> !pwr_q);

  // R2: no main turn-on while its gap runs without a sense release
  p_no_early_main_r2: assert property (@(posedge clk) disable iff (rst)
    (en && cmd_s && run_main && !done_main && !(mode_main && zv_main_s)) |=> !pwr_q);

  // R4: no aux turn-on while its gap runs without a sense release
  p_no_early_aux_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !cmd_s && run_aux && !done_aux && !(mode_aux && zv_aux_s)) |=> !auxc_q);

  // R6: a cancelled main wait returns to aux conduction
  p_main_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    main_cancel |=> (auxc_q && !pwr_q));

  // R6: a cancelled aux wait keeps the aux switch off
  p_aux_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    aux_cancel |=> (!auxc_q && !pwr_q));

  // R8: enable low means sleep on the next cycle
  p_sleep_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwr_q && !auxc_q && !oe_q));

  // R9: leaving sleep never turns the main switch on at once
  p_wake_low_r9: assert property (@(posedge clk) disable iff (rst)
    (en && !oe_q) |=> (!pwr_q && oe_q));

endmodule

// File: rtl/cgate_seq.sv
module cgate_seq
  import cgate_seq_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter bit AUX_INV     = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pwm_in,
  input  logic             zv_main,
  input  logic             zv_aux,
  input  logic             zv_mode_main,
  input  logic             zv_mode_aux,
  input  logic [CNT_W-1:0] dly_main,
  input  logic [CNT_W-1:0] dly_aux,
  output logic             pwr_out,
  output logic             aux_out,
  output logic             aux_oe
);

  localparam int N_SYNC  = 3;
  localparam int N_GAP   = 2;
  localparam int IDX_CMD = 0;
  localparam int IDX_ZVM = 1;
  localparam int IDX_ZVA = 2;
  localparam int GAP_MAIN = 0;
  localparam int GAP_AUX  = 1;

  logic [N_SYNC-1:0] raw_in, synced;
  logic [CNT_W-1:0]  gap_limit [N_GAP];
  logic [N_GAP-1:0]  gap_run, gap_done;
  logic              pwr_q, auxc_q, oe_q;

  assign raw_in[IDX_CMD] = pwm_in;
  assign raw_in[IDX_ZVM] = zv_main;
  assign raw_in[IDX_ZVA] = zv_aux;

  cgate_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_in),
    .q_sync  (synced)
  );

  assign gap_limit[GAP_MAIN] = dly_main;
  assign gap_limit[GAP_AUX]  = dly_aux;

  generate
    for (genvar g = 0; g < N_GAP; g++) begin : g_gap
      cgate_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (gap_run[g]),
        .limit (gap_limit[g]),
        .done  (gap_done[g])
      );
    end
  endgenerate

  cgate_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cmd_s     (synced[IDX_CMD]),
    .zv_main_s (synced[IDX_ZVM]),
    .zv_aux_s  (synced[IDX_ZVA]),
    .mode_main (zv_mode_main),
    .mode_aux  (zv_mode_aux),
    .done_main (gap_done[GAP_MAIN]),
    .done_aux  (gap_done[GAP_AUX]),
    .run_main  (gap_run[GAP_MAIN]),
    .run_aux   (gap_run[GAP_AUX]),
    .pwr_q     (pwr_q),
    .auxc_q    (auxc_q),
    .oe_q      (oe_q)
  );

  generate
    if (AUX_INV) begin : g_aux_pch
      assign aux_out = !auxc_q;
    end else begin : g_aux_nch
      assign aux_out = auxc_q;
    end
  endgenerate

  assign pwr_out = pwr_q;
  assign aux_oe  = oe_q;

  // R10: the reset state is the sleep state
  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (!pwr_out && !aux_oe && (aux_out == AUX_INV)));

endmodule

// File: tb/tb_cgate_seq.sv
module tb_cgate_seq;

  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rst, en, pwm_in, zv_main, zv_aux, zv_mode_main, zv_mode_aux;
  logic [CNT_W-1:0] dly_main, dly_aux;
  logic pwr_out, aux_out, aux_oe;
  logic pwr_i, aux_i, oe_i;

  int errors = 0;
  int checks = 0;
  int ovl_err = 0;
  int inv_err = 0;
  int kp_rise, kp_fall, ka_rise, ka_fall;
  bit done_flag = 0;

  always #5 clk = ~clk;

  cgate_seq #(.CNT_W(CNT_W), .AUX_INV(1'b0)) dut (
    .clk(clk), .rst(rst), .en(en), .pwm_in(pwm_in),
    .zv_main(zv_main), .zv_aux(zv_aux),
    .zv_mode_main(zv_mode_main), .zv_mode_aux(zv_mode_aux),
    .dly_main(dly_main), .dly_aux(dly_aux),
    .pwr_out(pwr_out), .aux_out(aux_out), .aux_oe(aux_oe)
  );

  cgate_seq #(.CNT_W(CNT_W), .AUX_INV(1'b1)) dut_inv (
    .clk(clk), .rst(rst), .en(en), .pwm_in(pwm_in),
    .zv_main(zv_main), .zv_aux(zv_aux),
    .zv_mode_main(zv_mode_main), .zv_mode_aux(zv_mode_aux),
    .dly_main(dly_main), .dly_aux(dly_aux),
    .pwr_out(pwr_i), .aux_out(aux_i), .aux_oe(oe_i)
  );

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R7 and R11 monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (pwr_out && aux_out && aux_oe) ovl_err++;
    if (aux_i !== !aux_out || pwr_i !== pwr_out || oe_i !== aux_oe) inv_err++;
  end

  // Drive pwm_in to lvl now (at a falling edge) and record output edges.
  task automatic run_seq(input bit lvl, input int maxk, input int flip_k,
                         input int back_k, input int inj_k, input int inj_sel);
    bit pp, pa;
    pwm_in = lvl;
    pp = pwr_out; pa = aux_out;
    kp_rise = -1; kp_fall = -1; ka_rise = -1; ka_fall = -1;
    for (int k = 1; k <= maxk; k++) begin
      @(negedge clk);
      if (pwr_out && !pp && kp_rise < 0) kp_rise = k;
      if (!pwr_out && pp && kp_fall < 0) kp_fall = k;
      if (aux_out && !pa && ka_rise < 0) ka_rise = k;
      if (!aux_out && pa && ka_fall < 0) ka_fall = k;
      pp = pwr_out; pa = aux_out;
      if (k == flip_k) pwm_in = !lvl;
      if (k == back_k) pwm_in = lvl;
      if (k == inj_k) begin
        if (inj_sel == 1) zv_main = 1'b1;
        else              zv_aux  = 1'b1;
      end
    end
    zv_main = 1'b0;
    zv_aux  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int sleep_bad;
    rst = 1; en = 1; pwm_in = 0; zv_main = 0; zv_aux = 0;
    zv_mode_main = 0; zv_mode_aux = 0; dly_main = 3; dly_aux = 3;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pwr in reset", int'(pwr_out), 0);
    chk("R10 oe in reset", int'(aux_oe), 0);
    chk("R10 aux level in reset", int'(aux_out), 0);
    chk("R11 inverted aux level in reset", int'(aux_i), 1);
    rst = 0;
    repeat (20) @(negedge clk);
    chk("R9 aux conducting after start", int'(aux_out), 1);

    // R1 R2 R3 R4 R12 sweep over both gaps
    for (int t1 = 0; t1 <= 5; t1++) begin
      for (int t2 = 0; t2 <= 5; t2++) begin
        dly_main = CNT_W'(t1); dly_aux = CNT_W'(t2);
        run_seq(1'b1, 12, -1, -1, -1, 0);
        chk("R1 aux off latency", ka_fall, 3);
        chk((t1 == 0) ? "R12 main gap zero" : "R2 main gap", kp_rise - ka_fall, eff(t1));
        run_seq(1'b0, 12, -1, -1, -1, 0);
        chk("R3 pwr off latency", kp_fall, 3);
        chk((t2 == 0) ? "R12 aux gap zero" : "R4 aux gap", ka_rise - kp_fall, eff(t2));
      end
    end

    // R2 R4 longer gaps
    dly_main = 37; dly_aux = 50;
    run_seq(1'b1, 60, -1, -1, -1, 0);
    chk("R2 main gap 37", kp_rise, 40);
    run_seq(1'b0, 60, -1, -1, -1, 0);
    chk("R4 aux gap 50", ka_rise, 53);

    // R5 zero-voltage release
    dly_main = 40; zv_mode_main = 1;
    run_seq(1'b1, 20, -1, -1, 8, 1);
    chk("R5 main sense release", kp_rise, 11);
    dly_aux = 40; zv_mode_aux = 1;
    run_seq(1'b0, 20, -1, -1, 6, 2);
    chk("R5 pwr off before sense", kp_fall, 3);
    chk("R5 aux sense release", ka_rise, 9);
    dly_main = 7;
    run_seq(1'b1, 15, -1, -1, -1, 0);
    chk("R5 main timer bound", kp_rise, 10);
    dly_aux = 5;
    run_seq(1'b0, 15, -1, -1, -1, 0);
    chk("R5 aux timer bound", ka_rise, 8);
    zv_mode_main = 0; zv_mode_aux = 0;
    run_seq(1'b1, 15, -1, -1, 1, 1);
    chk("R5 main sense ignored", kp_rise, 10);
    run_seq(1'b0, 15, -1, -1, 1, 2);
    chk("R5 aux sense ignored", ka_rise, 8);

    // R6 cancel during main wait (one-cycle low glitch)
    dly_main = 10;
    run_seq(1'b1, 25, 5, 6, -1, 0);
    chk("R6 aux off", ka_fall, 3);
    chk("R6 aux back after cancel", ka_rise, 8);
    chk("R6 main gap restarted", kp_rise, 19);
    // R6 cancel during aux wait
    dly_aux = 10; dly_main = 4;
    run_seq(1'b0, 20, 5, -1, -1, 0);
    chk("R6 pwr off", kp_fall, 3);
    chk("R6 aux stays off", ka_rise, -1);
    chk("R6 full main gap after aux cancel", kp_rise, 12);

    // R8 sleep from main-on
    en = 0;
    @(negedge clk);
    chk("R8 pwr low in sleep", int'(pwr_out), 0);
    chk("R8 oe low in sleep", int'(aux_oe), 0);
    chk("R8 aux off level in sleep", int'(aux_out), 0);
    sleep_bad = 0;
    for (int k = 0; k < 20; k++) begin
      pwm_in = k[2];
      @(negedge clk);
      if (pwr_out || aux_oe || aux_out) sleep_bad++;
    end
    chk("R8 input ignored in sleep", sleep_bad, 0);

    // R9 wake with input high
    pwm_in = 1; dly_main = 6;
    repeat (5) @(negedge clk);
    en = 1;
    run_seq(1'b1, 10, -1, -1, -1, 0);
    chk("R9 wake high main gap", kp_rise, 7);
    chk("R9 wake high aux stays off", ka_rise, -1);
    chk("R9 oe after wake", int'(aux_oe), 1);

    // R10 reset mid-run
    rst = 1;
    @(negedge clk);
    chk("R10 pwr after reset", int'(pwr_out), 0);
    chk("R10 oe after reset", int'(aux_oe), 0);
    chk("R10 aux after reset", int'(aux_out), 0);
    rst = 0;
    repeat (20) @(negedge clk);

    // R9 wake with input low
    en = 0; pwm_in = 0; dly_aux = 5;
    repeat (5) @(negedge clk);
    en = 1;
    run_seq(1'b0, 12, -1, -1, -1, 0);
    chk("R9 wake low aux gap", ka_rise, 6);
    chk("R9 wake low pwr stays low", kp_rise, -1);

    // R2 R4 periodic run: 100-cycle period
    dly_main = 20; dly_aux = 30;
    for (int p = 0; p < 5; p++) begin
      run_seq(1'b1, 50, -1, -1, -1, 0);
      chk("R2 periodic main on", kp_rise, 23);
      run_seq(1'b0, 50, -1, -1, -1, 0);
      chk("R4 periodic aux on", ka_rise, 33);
    end

    chk("R7 overlap cycles", ovl_err, 0);
    chk("R11 polarity mismatches", inv_err, 0);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule